// File: doc/BRIEF.md
# Coprocessor control register bank

This block holds the small set of system registers that sit beside a floating-point or SIMD coprocessor and are reached by move-to and move-from register operations. There are five registers: a fixed identification word, two fixed feature words that describe what the coprocessor implements, a read/write status and control word, and a read/write exception word. Bit 30 of the exception word is the coprocessor's global enable.

Each cycle the requester may present one access: a valid strobe, a read/write flag, a 4-bit selector, a privilege flag and 32 bits of write data. The bank checks whether the access is allowed. The check uses the privilege level, the selected register, and the enable bit as it stood before this access. An allowed read returns the register's contents in the same cycle. An allowed write updates the register on the next rising clock edge. A write to a fixed register is allowed, but it changes nothing. A refused access raises the fault flag for that cycle, returns zero and leaves every register as it was.

Top module: `cpr_sysreg_bank`

## Requirements
- R1: The selector picks the register. 4'b0000 selects the identification word, 4'b0001 the status/control word, 4'b1000 the exception word, 4'b0111 feature word 0 and 4'b0110 feature word 1. An allowed read returns the selected register's contents combinationally in the same cycle.
- R2: Synchronous active-low reset loads the following values: identification 0x410330C2, status/control 0x00000000, exception 0x00000000, feature 0 0x11110222, feature 1 0x00011111.
- R3: A write to the identification word or to either feature word is allowed if the permission rules allow it. Such a write does not raise the fault flag and leaves the word's value unchanged.
- R4: An allowed write to the status/control word or to the exception word stores the full 32-bit write data at the next rising edge. A later read returns that value.
- R5: At privileged level, the identification, feature and exception words are accessible whether the enable bit (exception bit 30) is 0 or 1.
- R6: The status/control word is accessible at either privilege level only while the enable bit is 1. While the enable bit is 0, any access to it is refused.
- R7: At user level, every access to the identification, feature or exception words is refused.
- R8: A refused access drives the fault flag high in that cycle, returns read data 0 and changes no register.
- R9: A selector other than the five listed in R1 is refused at both privilege levels.
- R10: The enable bit used for the check is the registered value. A write that clears or sets it affects only the accesses that follow it, and the status/control contents survive a disable/re-enable cycle.
- R11: While no access is presented, the fault flag is 0 and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_vld | input | 1 | An access is presented this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read; meaningful only with acc_vld |
| acc_sel | input | 4 | Register selector |
| acc_priv | input | 1 | 1 = privileged level, 0 = user level |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data; 0 unless an allowed read is presented |
| acc_fault | output | 1 | High in the cycle of a refused access |

## Verification
The assertions assume that the access inputs are known and held steady for the whole cycle in which acc_vld is high. They also assume exactly one access per cycle, and that reset is held low over at least one rising edge before the first access. The bench meets these assumptions in the following ways. It changes every input only on the falling edge. It presents a single access per task step and drops acc_vld between steps. It holds rst_n low for two edges. It samples the combinational outputs 2 ns after driving, which is well before the next rising edge.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

  localparam int DW = 32;
  localparam int SW = 4;

  typedef enum logic [2:0] {
    RG_NONE, RG_IDENT, RG_CTRL, RG_EXCP, RG_FEAT0, RG_FEAT1
  } reg_id_e;

  localparam logic [SW-1:0] SEL_IDENT = 4'b0000;
  localparam logic [SW-1:0] SEL_CTRL  = 4'b0001;
  localparam logic [SW-1:0] SEL_EXCP  = 4'b1000;
  localparam logic [SW-1:0] SEL_FEAT0 = 4'b0111;
  localparam logic [SW-1:0] SEL_FEAT1 = 4'b0110;

  localparam logic [DW-1:0] RST_IDENT = 32'h4103_30C2;
  localparam logic [DW-1:0] RST_CTRL  = 32'h0000_0000;
  localparam logic [DW-1:0] RST_EXCP  = 32'h0000_0000;
  localparam logic [DW-1:0] RST_FEAT0 = 32'h1111_0222;
  localparam logic [DW-1:0] RST_FEAT1 = 32'h0001_1111;

  function automatic reg_id_e decode_sel(input logic [SW-1:0] s);
    case (s)
      SEL_IDENT: return RG_IDENT;
      SEL_CTRL:  return RG_CTRL;
      SEL_EXCP:  return RG_EXCP;
      SEL_FEAT0: return RG_FEAT0;
      SEL_FEAT1: return RG_FEAT1;
      default:   return RG_NONE;
    endcase
  endfunction

  // Permission rule: status/control follows the enable bit at both levels,
  // every other defined register needs privilege, unknown selectors never pass.
  function automatic logic access_ok(input reg_id_e r, input logic priv, input logic en);
    case (r)
      RG_NONE: return 1'b0;
      RG_CTRL: return en;
      default: return priv;
    endcase
  endfunction

  function automatic logic is_writable(input reg_id_e r);
    return (r == RG_CTRL) || (r == RG_EXCP);
  endfunction

endpackage

// File: rtl/cpr_access_gate.sv
module cpr_access_gate
  import cpr_pkg::*;
#(
  parameter int SEL_W = SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic             acc_priv,
  input  logic             en_bit,
  output reg_id_e          tgt,
  output logic             grant,
  output logic             deny
);

  logic ok;

  always_comb begin
    tgt   = decode_sel(acc_sel);
    ok    = access_ok(tgt, acc_priv, en_bit);
    grant = acc_vld & ok;
    deny  = acc_vld & ~ok;
  end

  // R7
  user_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !acc_priv && acc_sel != SEL_CTRL) |-> deny);

  // R6
  ctrl_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_sel == SEL_CTRL && !en_bit) |-> deny);

  // R9
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && tgt == RG_NONE) |-> deny);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> (!grant && !deny));

endmodule

// File: rtl/cpr_reg_store.sv
module cpr_reg_store
  import cpr_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int EN_POS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_ctrl,
  input  logic              we_excp,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] excp_q,
  output logic              en_bit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= DATA_W'(RST_CTRL);
      excp_q <= DATA_W'(RST_EXCP);
    end else begin
      if (we_ctrl) ctrl_q <= wdata;
      if (we_excp) excp_q <= wdata;
    end
  end

  assign en_bit = excp_q[EN_POS];

  // R4
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_ctrl |=> (ctrl_q == $past(wdata)));

  // R4
  excp_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_excp |=> (excp_q == $past(wdata)));

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ctrl |=> $stable(ctrl_q));

  // R8
  excp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_excp |=> $stable(excp_q));

endmodule

// File: rtl/cpr_sysreg_bank.sv
module cpr_sysreg_bank
  import cpr_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int SEL_W  = SW,
  parameter int EN_POS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic              acc_priv,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_fault
);

  reg_id_e           tgt;
  logic              grant, deny, en_bit;
  logic              rd_fire, wr_fire, we_ctrl, we_excp;
  logic [DATA_W-1:0] ctrl_q, excp_q, rd_val;

  cpr_access_gate #(.SEL_W(SEL_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_sel(acc_sel),
    .acc_priv(acc_priv), .en_bit(en_bit), .tgt(tgt), .grant(grant), .deny(deny)
  );

  assign rd_fire = grant & ~acc_wr;
  assign wr_fire = grant & acc_wr & is_writable(tgt);
  assign we_ctrl = wr_fire & (tgt == RG_CTRL);
  assign we_excp = wr_fire & (tgt == RG_EXCP);

  cpr_reg_store #(.DATA_W(DATA_W), .EN_POS(EN_POS)) u_store (
    .clk(clk), .rst_n(rst_n), .we_ctrl(we_ctrl), .we_excp(we_excp),
    .wdata(acc_wdata), .ctrl_q(ctrl_q), .excp_q(excp_q), .en_bit(en_bit)
  );

  always_comb begin
    case (tgt)
      RG_IDENT: rd_val = DATA_W'(RST_IDENT);
      RG_CTRL:  rd_val = ctrl_q;
      RG_EXCP:  rd_val = excp_q;
      RG_FEAT0: rd_val = DATA_W'(RST_FEAT0);
      RG_FEAT1: rd_val = DATA_W'(RST_FEAT1);
      default:  rd_val = '0;
    endcase
  end

  assign acc_rdata = rd_fire ? rd_val : '0;
  assign acc_fault = deny;

  // R8
  deny_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> (acc_rdata == '0));

  // R8
  deny_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fault |-> (!we_ctrl && !we_excp));

  // R3
  ident_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && acc_sel == SEL_IDENT) |-> (acc_rdata == DATA_W'(RST_IDENT)));

  // R5
  priv_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && acc_priv && (acc_sel == SEL_IDENT || acc_sel == SEL_EXCP ||
     acc_sel == SEL_FEAT0 || acc_sel == SEL_FEAT1)) |-> !acc_fault);

endmodule

// File: tb/tb_cpr_sysreg_bank.sv
`timescale 1ns/1ps
module tb_cpr_sysreg_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_vld, acc_wr, acc_priv;
  logic [3:0]  acc_sel;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        acc_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpr_sysreg_bank dut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_priv(acc_priv), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_fault(acc_fault)
  );

  localparam logic [3:0] S_ID = 4'b0000, S_CT = 4'b0001, S_EX = 4'b1000,
                         S_F0 = 4'b0111, S_F1 = 4'b0110;
  localparam logic [31:0] V_ID = 32'h410330C2, V_F0 = 32'h11110222, V_F1 = 32'h00011111;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [3:0] sel, input logic priv,
                     input logic [31:0] wd, output logic [31:0] rd, output logic ft);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = wr; acc_sel = sel; acc_priv = priv; acc_wdata = wd;
    #2;
    rd = acc_rdata; ft = acc_fault;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] rd; logic ft;
    acc(0, S_ID, 1, 0, rd, ft); chk("R2 ident", rd, V_ID); chk("R1 ident fault", {31'b0, ft}, 0);
    acc(0, S_F0, 1, 0, rd, ft); chk("R2 feat0", rd, V_F0);
    acc(0, S_F1, 1, 0, rd, ft); chk("R2 feat1", rd, V_F1);
    acc(0, S_EX, 1, 0, rd, ft); chk("R2 excp", rd, 32'h0); chk("R5 excp en=0", {31'b0, ft}, 0);
    acc(0, S_CT, 1, 0, rd, ft); chk("R6 ctrl en=0 fault", {31'b0, ft}, 1); chk("R8 rdata", rd, 0);
  endtask

  task automatic t_enable();
    logic [31:0] rd; logic ft;
    acc(1, S_EX, 1, 32'h4000_00A5, rd, ft); chk("R4 excp write fault", {31'b0, ft}, 0);
    acc(0, S_EX, 1, 0, rd, ft); chk("R4 excp readback", rd, 32'h4000_00A5);
    acc(0, S_CT, 1, 0, rd, ft); chk("R2 ctrl reset", rd, 32'h0); chk("R6 ctrl en=1", {31'b0, ft}, 0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] rd; logic ft;
    acc(1, S_CT, 1, 32'hDEAD_BEEF, rd, ft);
    acc(0, S_CT, 1, 0, rd, ft); chk("R4 ctrl priv", rd, 32'hDEAD_BEEF);
    acc(1, S_CT, 0, 32'h1234_5678, rd, ft); chk("R6 user ctrl write", {31'b0, ft}, 0);
    acc(0, S_CT, 0, 0, rd, ft); chk("R6 user ctrl read", rd, 32'h1234_5678);
  endtask

  task automatic t_readonly();
    logic [31:0] rd; logic ft;
    acc(1, S_ID, 1, 32'hFFFF_FFFF, rd, ft); chk("R3 ident write fault", {31'b0, ft}, 0);
    acc(0, S_ID, 1, 0, rd, ft); chk("R3 ident kept", rd, V_ID);
    acc(1, S_F0, 1, 32'h0, rd, ft);
    acc(0, S_F0, 1, 0, rd, ft); chk("R3 feat0 kept", rd, V_F0);
    acc(1, S_F1, 1, 32'hA5A5_A5A5, rd, ft);
    acc(0, S_F1, 1, 0, rd, ft); chk("R3 feat1 kept", rd, V_F1);
    acc(0, S_CT, 1, 0, rd, ft); chk("R3 ctrl untouched", rd, 32'h1234_5678);
  endtask

  task automatic t_user();
    logic [31:0] rd; logic ft;
    acc(0, S_ID, 0, 0, rd, ft); chk("R7 user ident", {31'b0, ft}, 1); chk("R8 user ident rd", rd, 0);
    acc(0, S_F0, 0, 0, rd, ft); chk("R7 user feat0", {31'b0, ft}, 1);
    acc(0, S_F1, 0, 0, rd, ft); chk("R7 user feat1", {31'b0, ft}, 1);
    acc(0, S_EX, 0, 0, rd, ft); chk("R7 user excp", {31'b0, ft}, 1); chk("R8 user excp rd", rd, 0);
    acc(1, S_EX, 0, 32'h0, rd, ft); chk("R7 user excp write", {31'b0, ft}, 1);
    acc(0, S_EX, 1, 0, rd, ft); chk("R8 excp unchanged", rd, 32'h4000_00A5);
  endtask

  task automatic t_undef();
    logic [31:0] rd; logic ft;
    acc(0, 4'b0010, 1, 0, rd, ft); chk("R9 sel 0010", {31'b0, ft}, 1); chk("R9 sel 0010 rd", rd, 0);
    acc(0, 4'b1111, 1, 0, rd, ft); chk("R9 sel 1111", {31'b0, ft}, 1);
    acc(1, 4'b1001, 1, 32'h0, rd, ft); chk("R9 sel 1001 write", {31'b0, ft}, 1);
    acc(1, 4'b0011, 0, 32'h0, rd, ft); chk("R9 user sel 0011", {31'b0, ft}, 1);
    acc(0, S_EX, 1, 0, rd, ft); chk("R8 excp after undef", rd, 32'h4000_00A5);
    acc(0, S_CT, 1, 0, rd, ft); chk("R8 ctrl after undef", rd, 32'h1234_5678);
  endtask

  task automatic t_live_enable();
    logic [31:0] rd; logic ft;
    acc(1, S_EX, 1, 32'h0000_00A5, rd, ft); chk("R10 clear write ok", {31'b0, ft}, 0);
    acc(0, S_CT, 1, 0, rd, ft); chk("R10 ctrl after clear", {31'b0, ft}, 1); chk("R10 ctrl rd 0", rd, 0);
    acc(1, S_CT, 1, 32'hFFFF_0000, rd, ft); chk("R6 ctrl write en=0", {31'b0, ft}, 1);
    acc(0, S_CT, 0, 0, rd, ft); chk("R6 user ctrl en=0", {31'b0, ft}, 1);
    acc(0, S_ID, 1, 0, rd, ft); chk("R5 ident en=0", rd, V_ID);
    acc(1, S_EX, 1, 32'h4000_0000, rd, ft);
    acc(0, S_CT, 1, 0, rd, ft); chk("R10 ctrl survives", rd, 32'h1234_5678);
  endtask

  task automatic t_idle();
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0; acc_sel = S_ID; acc_priv = 1'b1;
    #2;
    chk("R11 idle fault", {31'b0, acc_fault}, 0);
    chk("R11 idle rdata", acc_rdata, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_vld = 1'b0; acc_wr = 1'b0; acc_sel = '0;
    acc_priv = 1'b0; acc_wdata = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R11 reset fault", {31'b0, acc_fault}, 0);
    chk("R11 reset rdata", acc_rdata, 0);
    t_reset();
    t_enable();
    t_ctrl_rw();
    t_readonly();
    t_user();
    t_undef();
    t_live_enable();
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule